// File: doc/BRIEF.md
# Packed 12-bit Sector Buffer

This block holds one disk sector of 128 bytes (single density) or 256 bytes (double density). A host moves data through a word-serial port, and the disk side reaches the same storage as a plain byte-addressed array. A command selects fill (host to buffer) or empty (buffer to host), an 8-bit or a 12-bit word mode, and the density.

In 8-bit mode each host transfer carries one byte. In 12-bit mode the words are packed end to end as a bit stream, most significant bit first, so two words take three bytes. An even word takes a whole byte plus the upper nibble of the next byte. An odd word takes the lower nibble of that shared byte plus one whole byte. When a 12-bit fill ends, the bytes after the packed region are cleared.

Each word is paced by a transfer-ready flag. When the sector's word count is used up the block gives a one-cycle done pulse and becomes idle again.

Top module: `sbp_top`

## Requirements
- R1: After reset, busy, xfer_ready and done are all 0.
- R2: The sector holds 128 bytes when cmd_double=0 and 256 bytes when cmd_double=1. A command moves that many words in 8-bit mode (cmd_bytes=1) and half that many in 12-bit mode (cmd_bytes=0). No byte above the sector is touched.
- R3: In 8-bit mode, fill word n is stored at byte address n as host_wdata[7:0]. While emptying, host_rdata equals acc_in OR {4'b0000, byte n}.
- R4: In 12-bit mode, even word w with n even goes to k = floor(3n/2) as byte[k] = w[11:4] and byte[k+1][7:4] = w[3:0].
- R5: In 12-bit mode, odd word w sets byte[k][3:0] = w[11:8] and keeps the upper nibble the previous even word placed there, and sets byte[k+1] = w[7:0].
- R6: A 12-bit empty returns {byte[k], byte[k+1][7:4]} for an even word and {byte[k][3:0], byte[k+1]} for an odd word, whatever acc_in holds.
- R7: At the end of a 12-bit fill, every byte from floor(3·count/2) to the last byte of the sector reads as zero.
- R8: In an empty, the host read that takes the last word produces done with no further xfer_ready, and host_rdata keeps the last word.
- R9: xfer_ready falls for at least one cycle after each accepted word and rises again only while words remain. host_wr during an empty and host_rd during a fill are ignored.
- R10: cmd_start is ignored while busy. Each accepted command restarts at word 0.
- R11: While idle, disk_en with disk_we writes disk_wdata to disk_addr, and a disk read returns the byte on disk_rdata one cycle later. While busy, disk accesses are ignored.
- R12: A disk access issued in the same cycle as an accepted cmd_start is carried out before the command's first buffer access.
- R13: done is a single-cycle pulse, and busy is 0 from the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a command (taken only when idle) |
| cmd_fill | input | 1 | 1 = fill from host, 0 = empty to host |
| cmd_bytes | input | 1 | 1 = 8-bit words, 0 = packed 12-bit words |
| cmd_double | input | 1 | 1 = 256-byte sector, 0 = 128-byte sector |
| host_wr | input | 1 | Host offers host_wdata (fill) |
| host_wdata | input | 12 | Host write word |
| host_rd | input | 1 | Host takes host_rdata (empty) |
| acc_in | input | 12 | Host accumulator merged into 8-bit reads |
| host_rdata | output | 12 | Data register seen by the host |
| xfer_ready | output | 1 | A word may be transferred |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| disk_en | input | 1 | Disk-side byte access request |
| disk_we | input | 1 | Disk-side write when 1, read when 0 |
| disk_addr | input | 8 | Disk-side byte address |
| disk_wdata | input | 8 | Disk-side write byte |
| disk_rdata | output | 8 | Disk-side read byte, one cycle after the request |

## Verification
The disk port and the command engine share one single-port store, so a disk access and the start of a command can fall in the same cycle. The bench issues a disk write to byte 0 together with the cmd_start of an 8-bit empty, and requires the first word the host receives to carry the newly written byte. It also issues a disk write during a fill and requires the target byte, which lies outside the sector, to keep its earlier value. This shows the disk is shut out only while a command owns the store.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL_WAIT,
    ST_FILL_TAIL,
    ST_CLEAR,
    ST_EMPTY_CHK,
    ST_EMPTY_B1,
    ST_EMPTY_FORM,
    ST_EMPTY_WAIT
  } sbp_state_e;

  // byte offset of packed word n: floor(3n/2)
  function automatic logic [15:0] pk_offset(input logic [15:0] n);
    return n + (n >> 1);
  endfunction

  // number of words a command moves
  function automatic logic [15:0] pk_count(input logic [15:0] sd_bytes,
                                           input logic dbl, input logic bytes);
    logic [15:0] per;
    per = dbl ? (sd_bytes << 1) : sd_bytes;
    return bytes ? per : (per >> 1);
  endfunction

  // first byte touched by a 12-bit word
  function automatic logic [7:0] pk_lead(input logic [11:0] w, input logic odd,
                                         input logic [3:0] keep);
    return odd ? {keep, w[11:8]} : w[11:4];
  endfunction

  // second byte touched by a 12-bit word
  function automatic logic [7:0] pk_trail(input logic [11:0] w, input logic odd);
    return odd ? w[7:0] : {w[3:0], 4'h0};
  endfunction

  // rebuild a 12-bit word from its two bytes
  function automatic logic [11:0] pk_join(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic odd);
    return odd ? {b0[3:0], b1} : {b0, b1[7:4]};
  endfunction

endpackage

// File: rtl/sbp_store.sv
module sbp_store #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/sbp_engine.sv
module sbp_engine
  import sbp_pkg::*;
#(
  parameter int SD_BYTES = 128,
  localparam int MAXB = 2 * SD_BYTES,
  localparam int AW = $clog2(MAXB),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_fill,
  input  logic          cmd_bytes,
  input  logic          cmd_double,
  input  logic          host_wr,
  input  logic [11:0]   host_wdata,
  input  logic          host_rd,
  input  logic [11:0]   acc_in,
  output logic [11:0]   host_rdata,
  output logic          xfer_ready,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  sbp_state_e    state;
  logic [PW-1:0] ptr, cnt, zptr;
  logic          mode_fill, mode_bytes, mode_double;
  logic [11:0]   dreg;
  logic [3:0]    nib;
  logic [7:0]    hold;
  logic          done_q;

  // named internal events
  logic          fill_take, empty_take, clear_wr, empty_end, cmd_take;
  logic [PW-1:0] koff, koff1, ptr_nx, tail_lo, last_byte, cmd_cnt;

  assign koff      = PW'(pk_offset(16'(ptr)));
  assign koff1     = koff + PW'(1);
  assign ptr_nx    = ptr + PW'(1);
  assign tail_lo   = PW'(pk_offset(16'(cnt)));
  assign last_byte = (mode_double ? PW'(MAXB) : PW'(SD_BYTES)) - PW'(1);
  assign cmd_cnt   = PW'(pk_count(16'(SD_BYTES), cmd_double, cmd_bytes));

  assign cmd_take   = (state == ST_IDLE) && cmd_start;
  assign fill_take  = (state == ST_FILL_WAIT) && host_wr;
  assign empty_take = (state == ST_EMPTY_WAIT) && host_rd;
  assign clear_wr   = (state == ST_CLEAR);
  assign empty_end  = (state == ST_EMPTY_CHK) && (ptr >= cnt);

  assign xfer_ready = (state == ST_FILL_WAIT) || (state == ST_EMPTY_WAIT);
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign host_rdata = mode_bytes ? (acc_in | {4'h0, dreg[7:0]}) : dreg;

  // store access
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_FILL_WAIT: if (host_wr) begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = mode_bytes ? AW'(ptr) : AW'(koff);
        mem_wdata = mode_bytes ? host_wdata[7:0] : pk_lead(host_wdata, ptr[0], nib);
      end
      ST_FILL_TAIL: if (!mode_bytes) begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(koff1);
        mem_wdata = pk_trail(dreg, ptr[0]);
      end
      ST_CLEAR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = AW'(zptr);
      end
      ST_EMPTY_CHK: if (ptr < cnt) begin
        mem_en    = 1'b1;
        mem_addr  = mode_bytes ? AW'(ptr) : AW'(koff);
      end
      ST_EMPTY_B1: begin
        mem_en    = 1'b1;
        mem_addr  = AW'(koff1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ptr         <= '0;
      cnt         <= '0;
      zptr        <= '0;
      mode_fill   <= 1'b0;
      mode_bytes  <= 1'b0;
      mode_double <= 1'b0;
      dreg        <= '0;
      nib         <= '0;
      hold        <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_start) begin
          mode_fill   <= cmd_fill;
          mode_bytes  <= cmd_bytes;
          mode_double <= cmd_double;
          cnt         <= cmd_cnt;
          ptr         <= '0;
          state       <= cmd_fill ? ST_FILL_WAIT : ST_EMPTY_CHK;
        end
        ST_FILL_WAIT: if (host_wr) begin
          dreg  <= host_wdata;
          if (!ptr[0]) nib <= host_wdata[3:0];
          state <= ST_FILL_TAIL;
        end
        ST_FILL_TAIL: begin
          ptr <= ptr_nx;
          if (ptr_nx < cnt) begin
            state <= ST_FILL_WAIT;
          end else if (!mode_bytes) begin
            zptr  <= PW'(pk_offset(16'(ptr_nx)));
            state <= ST_CLEAR;
          end else begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_CLEAR: begin
          zptr <= zptr + PW'(1);
          if (zptr == last_byte) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        ST_EMPTY_CHK: begin
          if (ptr >= cnt) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= mode_bytes ? ST_EMPTY_FORM : ST_EMPTY_B1;
          end
        end
        ST_EMPTY_B1: begin
          hold  <= mem_rdata;
          state <= ST_EMPTY_FORM;
        end
        ST_EMPTY_FORM: begin
          dreg  <= mode_bytes ? {4'h0, mem_rdata} : pk_join(hold, mem_rdata, ptr[0]);
          ptr   <= ptr_nx;
          state <= ST_EMPTY_WAIT;
        end
        ST_EMPTY_WAIT: if (host_rd) state <= ST_EMPTY_CHK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pointer never runs past the word count (R2, R9)
  assert_ptr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ptr <= cnt));

  // ready drops after each accepted word (R9)
  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take || empty_take) |=> !xfer_ready);

  // clearing stays inside the tail region and writes zero (R7)
  assert_clear_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |-> ((zptr >= tail_lo) && (zptr <= last_byte) && (mem_wdata == 8'h00)));

  // exhausted empty completes on the next cycle (R8)
  assert_empty_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty_end |=> (done && !xfer_ready));

  // done is a single pulse and coincides with idle (R13)
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // a command arriving while busy leaves the mode untouched (R10)
  assert_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && busy) |=> ($stable(mode_fill) && $stable(cnt) && $stable(mode_bytes)));
endmodule

// File: rtl/sbp_top.sv
module sbp_top #(
  parameter int SD_BYTES = 128,
  localparam int MAXB = 2 * SD_BYTES,
  localparam int AW = $clog2(MAXB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_fill,
  input  logic          cmd_bytes,
  input  logic          cmd_double,
  input  logic          host_wr,
  input  logic [11:0]   host_wdata,
  input  logic          host_rd,
  input  logic [11:0]   acc_in,
  output logic [11:0]   host_rdata,
  output logic          xfer_ready,
  output logic          busy,
  output logic          done,
  input  logic          disk_en,
  input  logic          disk_we,
  input  logic [AW-1:0] disk_addr,
  input  logic [7:0]    disk_wdata,
  output logic [7:0]    disk_rdata
);
  logic          eng_en, eng_we;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_wdata;
  logic          st_en, st_we;
  logic [AW-1:0] st_addr;
  logic [7:0]    st_wdata, st_rdata;
  logic          disk_grant;

  sbp_engine #(.SD_BYTES(SD_BYTES)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_fill   (cmd_fill),
    .cmd_bytes  (cmd_bytes),
    .cmd_double (cmd_double),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .acc_in     (acc_in),
    .host_rdata (host_rdata),
    .xfer_ready (xfer_ready),
    .busy       (busy),
    .done       (done),
    .mem_en     (eng_en),
    .mem_we     (eng_we),
    .mem_addr   (eng_addr),
    .mem_wdata  (eng_wdata),
    .mem_rdata  (st_rdata)
  );

  // the disk side owns the store whenever no command is running
  assign disk_grant = !busy;
  assign st_en      = disk_grant ? disk_en    : eng_en;
  assign st_we      = disk_grant ? disk_we    : eng_we;
  assign st_addr    = disk_grant ? disk_addr  : eng_addr;
  assign st_wdata   = disk_grant ? disk_wdata : eng_wdata;
  assign disk_rdata = st_rdata;

  sbp_store #(.DEPTH(MAXB)) u_store (
    .clk   (clk),
    .en    (st_en),
    .we    (st_we),
    .addr  (st_addr),
    .wdata (st_wdata),
    .rdata (st_rdata)
  );

  // the engine only touches the store while it holds a command (R11)
  assert_engine_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_en |-> busy);
endmodule

// File: tb/tb_sbp_top.sv
module tb_sbp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, cmd_fill, cmd_bytes, cmd_double;
  logic        host_wr, host_rd;
  logic [11:0] host_wdata, acc_in, host_rdata;
  logic        xfer_ready, busy, done;
  logic        disk_en, disk_we;
  logic [7:0]  disk_addr, disk_wdata, disk_rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] shadow [256];

  always #5 clk = ~clk;

  sbp_top dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] wval(input int n, input int s);
    return 12'((n * 37 + s * 101 + 5));
  endfunction

  function automatic logic [7:0] bval(input int n, input int s);
    return 8'((n * 29 + s * 13 + 1));
  endfunction

  // packed image as a MSB-first bit stream of 12-bit words
  function automatic logic [7:0] model_byte(input int j, input int nwords, input int s);
    logic [7:0] r;
    logic [11:0] w;
    r = 8'h00;
    if (j >= (12 * nwords) / 8) return 8'h00;
    for (int b = 0; b < 8; b++) begin
      w = wval((8 * j + b) / 12, s);
      r[7 - b] = w[11 - ((8 * j + b) % 12)];
    end
    return r;
  endfunction

  task automatic disk_write(input int a, input logic [7:0] d);
    disk_en = 1; disk_we = 1; disk_addr = 8'(a); disk_wdata = d;
    @(negedge clk);
    disk_en = 0; disk_we = 0;
  endtask

  task automatic disk_read(input int a, output logic [7:0] d);
    disk_en = 1; disk_we = 0; disk_addr = 8'(a);
    @(negedge clk);
    disk_en = 0;
    d = disk_rdata;
  endtask

  task automatic start(input bit f, input bit b, input bit dbl);
    cmd_start = 1; cmd_fill = f; cmd_bytes = b; cmd_double = dbl;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic fill_word(input logic [11:0] w);
    while (!xfer_ready) @(negedge clk);
    host_wr = 1; host_wdata = w;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic empty_word(output logic [11:0] w);
    while (!xfer_ready) @(negedge clk);
    w = host_rdata;
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  // wait for done; ready must stay low meanwhile
  task automatic wait_done(input string req);
    bit seen = 0;
    bit rdy = 0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin seen = 1; break; end
      if (xfer_ready) rdy = 1;
      @(negedge clk);
    end
    chk(seen, {req, " done pulse"}, int'(seen), 1);
    chk(!rdy, {req, " no ready before done"}, int'(rdy), 0);
    chk(!busy, "R13 idle with done", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R13 done single pulse", int'(done), 0);
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] d;
    for (int j = 0; j < 256; j++) begin
      disk_read(j, d);
      chk(d == shadow[j], $sformatf("%s byte %0d", tag, j), int'(d), int'(shadow[j]));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic [11:0] w;
    rst_n = 0; cmd_start = 0; cmd_fill = 0; cmd_bytes = 0; cmd_double = 0;
    host_wr = 0; host_rd = 0; host_wdata = 0; acc_in = 0;
    disk_en = 0; disk_we = 0; disk_addr = 0; disk_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !xfer_ready && !done, "R1 reset state", {busy, xfer_ready, done}, 0);

    // R11 disk port while idle
    for (int j = 0; j < 256; j++) begin disk_write(j, 8'hA5); shadow[j] = 8'hA5; end
    disk_read(7, d);   chk(d == 8'hA5, "R11 disk readback", d, 8'hA5);
    disk_write(9, 8'h3E); shadow[9] = 8'h3E;
    disk_read(9, d);   chk(d == 8'h3E, "R11 disk readback", d, 8'h3E);

    // 8-bit single-density fill with collisions (R3, R9, R10, R11)
    start(1, 1, 0);
    for (int n = 0; n < 128; n++) begin
      if (n == 10) begin
        while (!xfer_ready) @(negedge clk);
        cmd_start = 1; cmd_fill = 0;
        @(negedge clk);
        cmd_start = 0;
        chk(xfer_ready && busy, "R10 command ignored while busy", xfer_ready, 1);
      end
      if (n == 20) begin
        while (!xfer_ready) @(negedge clk);
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        chk(xfer_ready, "R9 host_rd ignored in fill", xfer_ready, 1);
      end
      if (n == 30) disk_write(200, 8'h3C);
      fill_word({4'hF, bval(n, 1)});
      shadow[n] = bval(n, 1);
    end
    wait_done("R2 8-bit fill");
    compare_all("R3 R11 8-bit fill");

    // 8-bit empty, accumulator merge, ignored host_wr (R3, R8, R9)
    acc_in = 12'hA00;
    start(0, 1, 0);
    for (int n = 0; n < 128; n++) begin
      if (n == 5) begin
        while (!xfer_ready) @(negedge clk);
        w = host_rdata;
        host_wr = 1; host_wdata = 12'h000;
        @(negedge clk);
        host_wr = 0;
        chk(xfer_ready && host_rdata == w, "R9 host_wr ignored in empty", host_rdata, w);
      end
      empty_word(w);
      chk(w == (12'hA00 | {4'h0, bval(n, 1)}), "R3 8-bit read", w, 12'hA00 | {4'h0, bval(n, 1)});
    end
    wait_done("R8 empty end");
    chk(host_rdata == (12'hA00 | {4'h0, bval(127, 1)}), "R8 data kept", host_rdata,
        12'hA00 | {4'h0, bval(127, 1)});
    disk_read(5, d); chk(d == shadow[5], "R9 no write from host_wr", d, shadow[5]);

    // 12-bit single density (R4, R5, R6, R7, R2)
    start(1, 0, 0);
    for (int n = 0; n < 64; n++) fill_word(wval(n, 2));
    wait_done("R7 12-bit fill");
    for (int j = 0; j < 128; j++) shadow[j] = model_byte(j, 64, 2);
    compare_all("R4 R5 R7 packed single");
    acc_in = 12'hFFF;
    start(0, 0, 0);
    for (int n = 0; n < 64; n++) begin
      empty_word(w);
      chk(w == wval(n, 2), "R6 12-bit read", w, wval(n, 2));
    end
    wait_done("R8 12-bit empty end");

    // 12-bit double density (R2, R4, R5, R7)
    start(1, 0, 1);
    for (int n = 0; n < 128; n++) fill_word(wval(n, 3));
    wait_done("R2 12-bit double fill");
    for (int j = 0; j < 256; j++) shadow[j] = model_byte(j, 128, 3);
    compare_all("R4 R5 R7 packed double");
    start(0, 0, 1);
    for (int n = 0; n < 128; n++) begin
      empty_word(w);
      chk(w == wval(n, 3), "R6 12-bit double read", w, wval(n, 3));
    end
    wait_done("R2 12-bit double empty");

    // 8-bit double density (R2)
    start(1, 1, 1);
    for (int n = 0; n < 256; n++) begin fill_word({4'h0, bval(n, 4)}); shadow[n] = bval(n, 4); end
    wait_done("R2 8-bit double fill");
    compare_all("R2 8-bit double");

    // same-cycle disk write and command start, then pointer restart (R12, R10)
    acc_in = 12'h000;
    cmd_start = 1; cmd_fill = 0; cmd_bytes = 1; cmd_double = 0;
    disk_en = 1; disk_we = 1; disk_addr = 8'h00; disk_wdata = 8'h77;
    @(negedge clk);
    cmd_start = 0; disk_en = 0; disk_we = 0;
    shadow[0] = 8'h77;
    for (int n = 0; n < 128; n++) begin
      empty_word(w);
      chk(w == {4'h0, shadow[n]}, n == 0 ? "R12 same-cycle write seen" : "R3 8-bit read",
          w, {4'h0, shadow[n]});
    end
    wait_done("R8 empty end");
    start(0, 1, 0);
    empty_word(w);
    chk(w == 12'h077, "R10 pointer restarts at word 0", w, 12'h077);
    for (int n = 1; n < 128; n++) empty_word(w);
    wait_done("R8 empty end");

    finish_run();
  end
endmodule